// File: doc/BRIEF.md
# Clause 22 Management Interface Master

This block is a register-mapped master for the two-wire PHY management interface. A host programs a clock divider and an enable bit, places a 16-bit value in a data register when it wants to write, and then writes a command word. The command word carries a PHY address, a register address, an operation code and a start bit. The block then produces a full Clause 22 frame on MDC and MDIO. A read frame returns the value from the PHY through a read-data register.

The management clock runs only while a frame is in flight. Between frames the clock is parked low and the data line is released. A ready flag in the command register lets software poll for completion. Any command or divider change made while a frame is running is dropped, so the frame on the wire always matches what was accepted.

The register bus has single-cycle strobes. Read data is registered and appears in the cycle after the read strobe.

Top module: `mdio_master`

## Requirements
- R1: While a frame runs, MDC has a period of 2*(div+1) host clocks, where div is control-register bits [5:0]. div=0 gives half the host clock.
- R2: Control-register bit 6 enables the clock. While this bit is 0, a command with the start bit set launches no frame and MDC makes no edge. While no frame runs, MDC is 0 and the MDIO output enable is 0.
- R3: The command register (offset 0x4) takes the PHY address in [28:24], the register address in [20:16], the opcode in [15:14] (10 = read, 01 = write) and the start bit in bit 11. Reading it back returns the stored fields with bit 11 at 0.
- R4: Command bit 7 (ready, read-only) is 1 after reset and whenever the engine is idle. It reads 0 from the cycle after an accepted start until the frame ends.
- R5: A write frame is sent MSB first as: 32 ones, then 01, then opcode 01, then PHY address, then register address, then turnaround 10, then the 16 bits held in the write-data register (offset 0x8).
- R6: A read frame sends opcode 10 and releases MDIO (output enable 0) for both turnaround bits and all 16 data bits. Data is sampled at each MDC rise. Afterwards, offset 0xC returns the value in [15:0] with [31:16] at 0.
- R7: MDIO and its output enable change only at a falling MDC edge or at frame start. They hold steady for the whole MDC-high phase.
- R8: While ready is 0, writes to the command register and the control register are ignored. The stored fields are unchanged and no second frame follows.
- R9: A command with the start bit set and an opcode of 00 or 11 starts no frame, and ready stays 1.
- R10: After reset, control reads 0. Control and write-data contents read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after bus_rd |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line value |

## Verification
Two events can land in the same cycle: accepting a command, and the ready flag going low as the engine becomes busy. The bench writes a command and reads the status on the very next bus access, and it requires ready to read 0. The bench also writes a second command and a new divider while a frame is still shifting. This checks that the busy engine wins: the captured frame, the register readback and the absence of a follow-on frame must all show that the late writes had no effect.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int BUS_W      = 32;
  localparam int DATA_W     = 16;
  localparam int FRAME_BITS = 64;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int TA_IDX     = 46;
  localparam int DATA_IDX   = 48;

  localparam logic [3:0] A_CTRL  = 4'h0;
  localparam logic [3:0] A_CMD   = 4'h4;
  localparam logic [3:0] A_WDATA = 4'h8;
  localparam logic [3:0] A_RDATA = 4'hC;

  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;

  localparam int START_BIT = 11;
  localparam int READY_BIT = 7;

  typedef struct packed {
    logic [1:0] op;
    logic [4:0] phy;
    logic [4:0] regad;
  } mgmt_cmd_t;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             tick;

  assign tick   = run_i && (cnt_q == div_i);
  assign rise_o = tick && !mdc_o;
  assign fall_o = tick && mdc_o;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q <= '0;
      mdc_o <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_o <= ~mdc_o;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R1
  mdc_period_chk: assert property (@(posedge clk) disable iff (rst)
    run_i && (cnt_q != div_i) |=> $stable(mdc_o));
endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  mgmt_cmd_t         cmd_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              busy_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [FRAME_BITS-1:0] frame_q;
  logic [IDX_W-1:0]      idx_q;
  logic [IDX_W-1:0]      idx_nx;
  logic                  is_rd_q;
  logic [DATA_W-1:0]     shin_q;
  logic                  last_bit;

  assign idx_nx   = idx_q + 1'b1;
  assign last_bit = (idx_q == IDX_W'(FRAME_BITS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q   <= '0;
      idx_q     <= '0;
      is_rd_q   <= 1'b0;
      shin_q    <= '0;
      busy_o    <= 1'b0;
      mdio_o    <= 1'b1;
      mdio_oe_o <= 1'b0;
      rdata_o   <= '0;
    end else if (start_i && !busy_o) begin
      frame_q   <= {{(FRAME_BITS-32){1'b1}}, 2'b01, cmd_i.op, cmd_i.phy, cmd_i.regad,
                    2'b10, (cmd_i.op == OP_RD) ? {DATA_W{1'b0}} : wdata_i};
      idx_q     <= '0;
      is_rd_q   <= (cmd_i.op == OP_RD);
      busy_o    <= 1'b1;
      mdio_o    <= 1'b1;
      mdio_oe_o <= 1'b1;
    end else if (busy_o) begin
      if (rise_i && is_rd_q && (idx_q >= IDX_W'(DATA_IDX)))
        shin_q <= {shin_q[DATA_W-2:0], mdio_i};
      if (fall_i) begin
        if (last_bit) begin
          busy_o    <= 1'b0;
          mdio_o    <= 1'b1;
          mdio_oe_o <= 1'b0;
          if (is_rd_q) rdata_o <= shin_q;
        end else begin
          idx_q     <= idx_nx;
          frame_q   <= {frame_q[FRAME_BITS-2:0], 1'b0};
          mdio_o    <= frame_q[FRAME_BITS-2];
          mdio_oe_o <= !(is_rd_q && (idx_nx >= IDX_W'(TA_IDX)));
        end
      end
    end
  end

  // R5
  preamble_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> mdio_oe_o && mdio_o);

  // R6
  read_release_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o && is_rd_q && fall_i && !last_bit && (idx_q >= IDX_W'(TA_IDX - 1)) |=> !mdio_oe_o);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W  = 6,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int EN_BIT = DIV_W;

  logic [DIV_W-1:0]  div_q;
  logic              en_q;
  mgmt_cmd_t         cmd_q;
  mgmt_cmd_t         cmd_new;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata;
  logic              busy;
  logic              cmd_acc;
  logic              op_ok;
  logic              start;
  logic              rise;
  logic              fall;

  assign cmd_new.phy   = bus_wdata[28:24];
  assign cmd_new.regad = bus_wdata[20:16];
  assign cmd_new.op    = bus_wdata[15:14];

  assign cmd_acc = bus_wr && (bus_addr == ADDR_W'(A_CMD)) && !busy;
  assign op_ok   = (cmd_new.op == OP_RD) || (cmd_new.op == OP_WR);
  assign start   = cmd_acc && bus_wdata[START_BIT] && en_q && op_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q   <= '0;
      en_q    <= 1'b0;
      cmd_q   <= '0;
      wdata_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == ADDR_W'(A_CTRL) && !busy) begin
        div_q <= bus_wdata[DIV_W-1:0];
        en_q  <= bus_wdata[EN_BIT];
      end
      if (cmd_acc) cmd_q <= cmd_new;
      if (bus_addr == ADDR_W'(A_WDATA)) wdata_q <= bus_wdata[DATA_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        ADDR_W'(A_CTRL):  bus_rdata <= BUS_W'({en_q, div_q});
        ADDR_W'(A_CMD):   bus_rdata <= (BUS_W'(cmd_q.phy) << 24) | (BUS_W'(cmd_q.regad) << 16)
                                     | (BUS_W'(cmd_q.op) << 14) | (BUS_W'(!busy) << READY_BIT);
        ADDR_W'(A_WDATA): bus_rdata <= BUS_W'(wdata_q);
        ADDR_W'(A_RDATA): bus_rdata <= BUS_W'(rdata);
        default:          bus_rdata <= '0;
      endcase
    end
  end

  mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk    (clk),
    .rst    (rst),
    .run_i  (en_q && busy),
    .div_i  (div_q),
    .mdc_o  (mdc),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_engine u_engine (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start),
    .cmd_i     (cmd_new),
    .wdata_i   (wdata_q),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_i),
    .busy_o    (busy),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe),
    .rdata_o   (rdata)
  );

  // R4
  ready_fall_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);

  // R2
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe && !mdc);

  // R7
  mdio_stable_chk: assert property (@(posedge clk) disable iff (rst)
    mdc && $past(mdc) |-> $stable(mdio_o) && $stable(mdio_oe));

  // R8
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(div_q) && $stable(en_q));

  // R6
  rdata_upper_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rd && (bus_addr == ADDR_W'(A_RDATA)) |=> (bus_rdata[31:16] == 16'h0));
endmodule

// File: tb/mdio_master_bench.sv
`timescale 1ns/1ps
module mdio_master_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;
  logic        phy_en = 1'b0;
  logic        phy_bit = 1'b1;

  int checks = 0;
  int errors = 0;
  int frames = 0;
  int rises = 0;
  int cyc = 0;
  int r7_viol = 0;
  bit done = 0;

  logic [15:0] phymem [32];
  logic [27:0] exp_q [$];
  logic [63:0] psh = '0;
  int          pcnt = 0;
  logic        p_rd = 1'b0;
  logic [4:0]  p_reg = '0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  assign mdio_i = mdio_oe ? mdio_o : (phy_en ? phy_bit : 1'b1);

  mdio_master u_mdio_master (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // PHY model and scoreboard monitor
  always @(posedge mdc) begin
    rises++;
    psh = {psh[62:0], mdio_i};
    pcnt++;
    if (pcnt == 46) begin
      p_rd  = (psh[11:10] == 2'b10);
      p_reg = psh[4:0];
    end
  end

  always @(negedge mdc) begin
    if (p_rd && pcnt >= 47 && pcnt <= 63) begin
      phy_en  = 1'b1;
      phy_bit = (pcnt == 47) ? 1'b0 : phymem[p_reg][63-pcnt];
    end else begin
      phy_en = 1'b0;
    end
    if (pcnt == 64) begin
      frames++;
      chk("R5 preamble", psh[63:32], 32'hFFFF_FFFF);
      chk("R5 start", {30'h0, psh[31:30]}, 32'h1);
      if (!p_rd) begin
        chk("R5 turnaround", {30'h0, psh[17:16]}, 32'h2);
        phymem[psh[22:18]] = psh[15:0];
      end
      if (exp_q.size() == 0) begin
        chk("R8 unexpected frame", 32'h1, 32'h0);
      end else begin
        logic [27:0] e;
        e = exp_q.pop_front();
        chk(p_rd ? "R6 read frame" : "R5 write frame", {4'h0, psh[29:18], psh[15:0]}, {4'h0, e});
      end
      pcnt = 0;
    end
  end

  always @(negedge clk) begin
    logic pm, po;
    if (!rst && mdc && pm && (mdio_o !== po)) r7_viol++;
    pm = mdc;
    po = mdio_o;
  end

  task automatic bwrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  function automatic logic [31:0] cmdw(input logic [1:0] op, input logic [4:0] phy,
                                       input logic [4:0] ra, input logic go);
    return (32'(phy) << 24) | (32'(ra) << 16) | (32'(op) << 14) | (32'(go) << 11);
  endfunction

  task automatic issue(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra,
                       input logic [15:0] d);
    if (op == 2'b01) bwrite(4'h8, {16'h0, d});
    exp_q.push_back({op, phy, ra, (op == 2'b10) ? phymem[ra] : d});
    bwrite(4'h4, cmdw(op, phy, ra, 1'b1));
  endtask

  task automatic wait_ready();
    logic [31:0] r;
    for (int i = 0; i < 3000; i++) begin
      bread(4'h4, r);
      if (r[7]) break;
    end
  endtask

  task automatic period(output int p);
    int t0;
    @(posedge mdc); t0 = cyc;
    @(posedge mdc); p = cyc - t0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int p, f0, e0;
    for (int i = 0; i < 32; i++) phymem[i] = 16'(i * 16'h0913 + 16'h8001);
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // reset state
    chk("R2 reset mdc", {31'h0, mdc}, 32'h0);
    chk("R2 reset oe", {31'h0, mdio_oe}, 32'h0);
    bread(4'h4, r); chk("R4 ready after reset", {31'h0, r[7]}, 32'h1);
    bread(4'h0, r); chk("R10 ctrl reset", r, 32'h0);

    // register readback
    bwrite(4'h0, 32'h40);
    bread(4'h0, r); chk("R10 ctrl readback", r, 32'h40);
    bwrite(4'h8, 32'h0000_5A3C);
    bread(4'h8, r); chk("R10 wdata readback", r, 32'h5A3C);

    // write frame at div 0, ready drops on the next access
    issue(2'b01, 5'd3, 5'd5, 16'hA5C3);
    bread(4'h4, r); chk("R4 ready low after start", {31'h0, r[7]}, 32'h0);
    wait_ready();
    bread(4'h4, r);
    chk("R3 cmd readback", r, cmdw(2'b01, 5'd3, 5'd5, 1'b0) | 32'h80);

    // div 0 period
    issue(2'b01, 5'd17, 5'd30, 16'h0001);
    period(p); chk("R1 period div0", p, 2);
    wait_ready();

    // div 1 period
    bwrite(4'h0, 32'h41);
    issue(2'b01, 5'd31, 5'd0, 16'hFFFE);
    period(p); chk("R1 period div1", p, 4);
    wait_ready();

    // read back what was written
    issue(2'b10, 5'd3, 5'd5, 16'h0);
    wait_ready();
    bread(4'hC, r); chk("R6 read data reg5", r, 32'h0000_A5C3);

    // div 3 read of a preset register
    bwrite(4'h0, 32'h43);
    issue(2'b10, 5'd9, 5'd9, 16'h0);
    period(p); chk("R1 period div3", p, 8);
    wait_ready();
    bread(4'hC, r); chk("R6 read data reg9", r, {16'h0, 16'(9 * 16'h0913 + 16'h8001)});

    // writes while busy are dropped
    bwrite(4'h0, 32'h40);
    issue(2'b01, 5'd2, 5'd7, 16'h1234);
    bwrite(4'h4, cmdw(2'b10, 5'd12, 5'd13, 1'b1));
    bwrite(4'h0, 32'h45);
    wait_ready();
    f0 = frames;
    repeat (300) @(negedge clk);
    chk("R8 no second frame", frames, f0);
    bread(4'h4, r); chk("R8 cmd unchanged", r, cmdw(2'b01, 5'd2, 5'd7, 1'b0) | 32'h80);
    bread(4'h0, r); chk("R8 ctrl unchanged", r, 32'h40);

    // bad opcodes
    f0 = frames;
    bwrite(4'h4, cmdw(2'b11, 5'd1, 5'd1, 1'b1));
    bread(4'h4, r); chk("R9 op11 ready", {31'h0, r[7]}, 32'h1);
    bwrite(4'h4, cmdw(2'b00, 5'd1, 5'd1, 1'b1));
    bread(4'h4, r); chk("R9 op00 ready", {31'h0, r[7]}, 32'h1);
    repeat (300) @(negedge clk);
    chk("R9 no frame", frames, f0);

    // disabled clock
    bwrite(4'h0, 32'h00);
    e0 = rises;
    f0 = frames;
    bwrite(4'h4, cmdw(2'b01, 5'd4, 5'd4, 1'b1));
    bread(4'h4, r); chk("R2 ready when disabled", {31'h0, r[7]}, 32'h1);
    repeat (100) @(negedge clk);
    chk("R2 no mdc edge", rises, e0);
    chk("R2 no frame", frames, f0);
    chk("R2 idle oe", {31'h0, mdio_oe}, 32'h0);

    chk("R5 scoreboard drained", exp_q.size(), 0);
    chk("R7 mdio steady while mdc high", r7_viol, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule